// File: doc/BRIEF.md
# Memory PLL Bring-Up and Reset Release Sequencer

This block starts the clock source of a memory subsystem and then takes the subsystem out of reset in a fixed order. A start pulse makes it power down and hold the PLL in reset. It then loads the divider word chosen by a frequency code, lets the loop settle for a fixed time and releases only the PLL reset. After that it waits a bounded time for lock and finally writes the enable bit to the PLL status register. Once the PLL is up, three reset lines are released one at a time. The sequencer then pauses.

While it pauses, other agents program the memory controller and load the PHY. When they are finished they pulse a continue input. The sequencer then frees the port resets and the controller reset in one write and reports completion. Delays are counted in clock cycles, derived from a clock-frequency parameter. An unsupported frequency code or a missing lock ends the run with a coded error. The error stays until a synchronous reset or a new start.

Top module: `pll_rst_seq`

## Requirements
- R1: A start pulse taken while idle, done or failed clears `pll_div_cfg`, `rst_ctrl`, `done`, `err` and `err_code` and sets `pll_ctrl` to 0x4B000000. That value has the reset bit 30 and the power-down bits 27, 25 and 24 set. A start pulse during a running sequence has no effect.
- R2: One cycle after the power-down word, frequency code 2 loads `pll_div_cfg` with 0x01204D01. The word holds reference divider 1 in bits 5:0, feedback divider 77 in bits 19:8, first post divider 2 in bits 22:20 and second post divider 1 in bits 26:24.
- R3: Any other frequency code sets `err` with `err_code` 1 (invalid) one cycle after the power-down word. `pll_div_cfg` and `rst_ctrl` stay 0.
- R4: Exactly SETTLE_US×CLK_MHZ cycles after the divider word appears, `pll_ctrl` becomes 0x0B000000. Only the reset bit is cleared.
- R5: `pll_lock` sampled high within LOCK_US×CLK_MHZ cycles of the reset clear causes a one-cycle `pll_stat_we` with `pll_stat_wdata` = 0x00010000 (bit 16) on the following cycle. Lock seen on the last cycle of the window still counts as lock.
- R6: If no lock is seen in that window, `pll_stat_we` still pulses with bit 16 in the same cycle as `err` rises, and `err_code` becomes 2 (timeout).
- R7: After a successful status write, `rst_ctrl` steps through 0x40, 0xC0 and 0xD0 on three consecutive cycles. Bit 6 is released first, then bit 7, then bit 4.
- R8: `rst_ctrl` then holds 0xD0 until `cont` pulses. A `cont` pulse at any other time has no effect. The pulse releases bits 8 to 12 and bit 5 together, so `rst_ctrl` becomes 0x1FF0, and `done` rises on the next cycle.
- R9: An error state holds its outputs until `rst` or a new start. `rst` returns every output to 0. `done` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the bring-up sequence (pulse) |
| freq_code | input | FREQ_W | Selects the PLL divider settings |
| cont | input | 1 | Continue to the second reset phase (pulse) |
| pll_lock | input | 1 | Lock flag from the PLL status register |
| pll_div_cfg | output | 32 | PLL divider configuration word |
| pll_ctrl | output | 32 | PLL reset and power-down control word |
| pll_stat_we | output | 1 | One-cycle write strobe to the PLL status register |
| pll_stat_wdata | output | 32 | Data for the status register write |
| rst_ctrl | output | 32 | Reset release word (a set bit means released) |
| done | output | 1 | Sequence completed |
| err | output | 1 | Sequence failed |
| err_code | output | 2 | 0 none, 1 invalid frequency code, 2 lock timeout |

## Verification
The arrival of lock and the end of the lock window can fall on the same clock edge. The bench raises `pll_lock` so that it is first sampled on the very edge where the window expires, and it checks that this edge gives a clean status write with no error. It also raises lock one cycle later and checks that a timeout is reported, with the status write landing in the same cycle as `err`. The bench counts cycles from the reset clear to the status strobe, so both outcomes are judged at the exact expected edge.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int WORD_W = 32;

  // PLL control word bit positions
  localparam int CTRL_RESET_BIT  = 30;
  localparam int CTRL_PD_POST    = 27;
  localparam int CTRL_PD_4PH     = 25;
  localparam int CTRL_PD_DAC     = 24;

  // PLL status write bit
  localparam int STAT_ENABLE_BIT = 16;

  // Reset release word bit positions
  localparam int REL_BUS_BIT     = 4;
  localparam int REL_CTRL_BIT    = 5;
  localparam int REL_PWROK_BIT   = 6;
  localparam int REL_CORE_BIT    = 7;
  localparam int REL_PORT0_BIT   = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PWRDN,
    ST_SETTLE,
    ST_LOCKW,
    ST_REL_PWROK,
    ST_REL_CORE,
    ST_REL_BUS,
    ST_HOLD,
    ST_FINAL,
    ST_DONE,
    ST_FAIL
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_INVAL   = 2'd1,
    ERR_TIMEOUT = 2'd2
  } err_e;

  typedef struct packed {
    logic [2:0]  pdiv2;
    logic [2:0]  pdiv1;
    logic [11:0] fbdiv;
    logic [5:0]  refdiv;
  } pll_div_t;

  function automatic logic [WORD_W-1:0] pack_div(input pll_div_t d);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[5:0]   = d.refdiv;
    w[19:8]  = d.fbdiv;
    w[22:20] = d.pdiv1;
    w[26:24] = d.pdiv2;
    return w;
  endfunction

endpackage

// File: rtl/pll_div_sel.sv
module pll_div_sel
  import pll_seq_pkg::*;
#(
  parameter int FREQ_W    = 2,
  parameter int SUPP_CODE = 2
) (
  input  logic [FREQ_W-1:0] code,
  output pll_div_t          div,
  output logic              valid
);

  always_comb begin
    div   = '0;
    valid = 1'b0;
    if (code == FREQ_W'(SUPP_CODE)) begin
      div.refdiv = 6'd1;
      div.fbdiv  = 12'd77;
      div.pdiv1  = 3'd2;
      div.pdiv2  = 3'd1;
      valid      = 1'b1;
    end
  end

endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = run && (cnt == '0);

  // A drained counter stays drained until reloaded (supports R4, R6 windows)
  p_hold_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/pll_rst_seq.sv
module pll_rst_seq
  import pll_seq_pkg::*;
#(
  parameter int CLK_MHZ   = 250,
  parameter int SETTLE_US = 2,
  parameter int LOCK_US   = 30,
  parameter int FREQ_W    = 2,
  parameter int NUM_PORTS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FREQ_W-1:0] freq_code,
  input  logic              cont,
  input  logic              pll_lock,
  output logic [31:0]       pll_div_cfg,
  output logic [31:0]       pll_ctrl,
  output logic              pll_stat_we,
  output logic [31:0]       pll_stat_wdata,
  output logic [31:0]       rst_ctrl,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code
);

  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int LOCK_CYC   = CLK_MHZ * LOCK_US;
  localparam int MAX_CYC    = (SETTLE_CYC > LOCK_CYC) ? SETTLE_CYC : LOCK_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  localparam logic [31:0] PD_WORD = (32'd1 << CTRL_RESET_BIT) | (32'd1 << CTRL_PD_POST)
                                  | (32'd1 << CTRL_PD_4PH)    | (32'd1 << CTRL_PD_DAC);
  localparam logic [31:0] RESET_MASK = 32'd1 << CTRL_RESET_BIT;
  localparam logic [31:0] STAT_WORD  = 32'd1 << STAT_ENABLE_BIT;

  seq_state_e state;
  logic       start_go;
  logic       div_valid;
  pll_div_t   div_sel;
  logic       tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic       tmr_run;
  logic       tmr_exp;
  logic [31:0] port_mask;
  logic [31:0] phase2_mask;

  // Port reset mask built from the port count
  for (genvar g = 0; g < 32; g++) begin : g_port_mask
    assign port_mask[g] = (g >= REL_PORT0_BIT) && (g < REL_PORT0_BIT + NUM_PORTS);
  end
  assign phase2_mask = port_mask | (32'd1 << REL_CTRL_BIT);

  pll_div_sel #(.FREQ_W(FREQ_W), .SUPP_CODE(2)) u_div (
    .code  (freq_code),
    .div   (div_sel),
    .valid (div_valid)
  );

  assign start_go = start && (state == ST_IDLE || state == ST_DONE || state == ST_FAIL);
  assign tmr_run  = (state == ST_SETTLE) || (state == ST_LOCKW);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state == ST_PWRDN && div_valid) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(SETTLE_CYC - 1);
    end else if (state == ST_SETTLE && tmr_exp) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(LOCK_CYC - 1);
    end
  end

  seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .expired  (tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      pll_div_cfg    <= '0;
      pll_ctrl       <= '0;
      pll_stat_we    <= 1'b0;
      pll_stat_wdata <= '0;
      rst_ctrl       <= '0;
      done           <= 1'b0;
      err            <= 1'b0;
      err_code       <= ERR_NONE;
    end else begin
      pll_stat_we <= 1'b0;
      if (start_go) begin
        state          <= ST_PWRDN;
        pll_div_cfg    <= '0;
        pll_ctrl       <= PD_WORD;
        pll_stat_wdata <= '0;
        rst_ctrl       <= '0;
        done           <= 1'b0;
        err            <= 1'b0;
        err_code       <= ERR_NONE;
      end else begin
        unique case (state)
          ST_PWRDN: begin
            if (div_valid) begin
              pll_div_cfg <= pack_div(div_sel);
              state       <= ST_SETTLE;
            end else begin
              err      <= 1'b1;
              err_code <= ERR_INVAL;
              state    <= ST_FAIL;
            end
          end
          ST_SETTLE: begin
            if (tmr_exp) begin
              pll_ctrl <= pll_ctrl & ~RESET_MASK;
              state    <= ST_LOCKW;
            end
          end
          ST_LOCKW: begin
            if (pll_lock) begin
              pll_stat_we    <= 1'b1;
              pll_stat_wdata <= STAT_WORD;
              state          <= ST_REL_PWROK;
            end else if (tmr_exp) begin
              pll_stat_we    <= 1'b1;
              pll_stat_wdata <= STAT_WORD;
              err            <= 1'b1;
              err_code       <= ERR_TIMEOUT;
              state          <= ST_FAIL;
            end
          end
          ST_REL_PWROK: begin
            rst_ctrl <= rst_ctrl | (32'd1 << REL_PWROK_BIT);
            state    <= ST_REL_CORE;
          end
          ST_REL_CORE: begin
            rst_ctrl <= rst_ctrl | (32'd1 << REL_CORE_BIT);
            state    <= ST_REL_BUS;
          end
          ST_REL_BUS: begin
            rst_ctrl <= rst_ctrl | (32'd1 << REL_BUS_BIT);
            state    <= ST_HOLD;
          end
          ST_HOLD: begin
            if (cont) begin
              rst_ctrl <= rst_ctrl | phase2_mask;
              state    <= ST_FINAL;
            end
          end
          ST_FINAL: begin
            done  <= 1'b1;
            state <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  // R1: an accepted start applies the power-down word with nothing released
  p_pd_first_r1: assert property (@(posedge clk) disable iff (rst)
    start_go |=> (pll_ctrl == PD_WORD && rst_ctrl == '0));

  // R4: divider word does not move while the settle delay runs
  p_div_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE && $past(state) == ST_SETTLE) |-> $stable(pll_div_cfg));

  // R5: the status strobe lasts a single cycle
  p_stat_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    pll_stat_we |=> !pll_stat_we);

  // R6: a timeout error comes with the status write
  p_timeout_write_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(err) && err_code == ERR_TIMEOUT) |-> (pll_stat_we && pll_stat_wdata == STAT_WORD));

  // R7: released reset bits are never taken back except by a new start
  p_rel_monotonic_r7: assert property (@(posedge clk) disable iff (rst)
    !start_go |=> ((rst_ctrl & $past(rst_ctrl)) == $past(rst_ctrl)));

  // R8: done only ever rises on a fully released reset word
  p_done_full_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (rst_ctrl == (phase2_mask | 32'h0000_00D0)));

  // R9: done and err are exclusive
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

endmodule

// File: tb/sim_pll_rst_seq.sv
module sim_pll_rst_seq;

  localparam int CLK_MHZ = 250;
  localparam int SETTLE  = 2 * CLK_MHZ;
  localparam int LOCKW   = 30 * CLK_MHZ;

  // code, lock delay (-1 = never), expected err_code, poke
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{2, 0,         0, 0},
    '{2, 37,        0, 1},
    '{2, LOCKW - 1, 0, 0},
    '{2, LOCKW,     2, 0},
    '{2, -1,        2, 1},
    '{0, 0,         1, 0},
    '{3, 0,         1, 0},
    '{1, 0,         1, 0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  freq_code = 2'd0;
  logic        cont = 1'b0;
  logic        pll_lock = 1'b0;
  logic [31:0] pll_div_cfg, pll_ctrl, pll_stat_wdata, rst_ctrl;
  logic        pll_stat_we, done, err;
  logic [1:0]  err_code;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pll_rst_seq #(.CLK_MHZ(CLK_MHZ)) u0 (
    .clk(clk), .rst(rst), .start(start), .freq_code(freq_code), .cont(cont),
    .pll_lock(pll_lock), .pll_div_cfg(pll_div_cfg), .pll_ctrl(pll_ctrl),
    .pll_stat_we(pll_stat_we), .pll_stat_wdata(pll_stat_wdata), .rst_ctrl(rst_ctrl),
    .done(done), .err(err), .err_code(err_code)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic run_seq(input int code, input int dly, input int exp_err, input int poke);
    int n;
    int m;
    int exp_m;
    freq_code = 2'(code);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R1 ctrl power-down", pll_ctrl, 32'h4B00_0000);
    check("R1 cleared outputs", {pll_div_cfg[15:0], rst_ctrl[13:0], done, err}, 32'h0);
    @(negedge clk);
    if (exp_err == 1) begin
      check("R3 invalid code error", {29'd0, err, err_code}, 32'h5);
      check("R3 nothing loaded", pll_div_cfg | rst_ctrl, 32'h0);
      cont = 1'b1;
      @(negedge clk) cont = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 error holds", {29'd0, err, err_code}, 32'h5);
      return;
    end
    check("R2 divider word", pll_div_cfg, 32'h0120_4D01);
    n = 0;
    while (pll_ctrl != 32'h0B00_0000 && n < SETTLE + 5) begin
      @(negedge clk);
      n++;
      cont  = (poke != 0 && n == 10);
      start = (poke != 0 && n == 20);
    end
    cont = 1'b0; start = 1'b0;
    check("R4 settle cycles", n, SETTLE);
    check("R4 only reset cleared", pll_ctrl, 32'h0B00_0000);
    m = 0;
    if (dly == 0) pll_lock = 1'b1;
    while (!pll_stat_we && m < LOCKW + 5) begin
      @(negedge clk);
      m++;
      if (m == dly) pll_lock = 1'b1;
    end
    exp_m = (dly >= 0 && dly <= LOCKW - 1) ? dly + 1 : LOCKW;
    check(exp_err == 2 ? "R6 timeout edge" : "R5 lock edge", m, exp_m);
    check("R5 status write data", pll_stat_wdata, 32'h0001_0000);
    if (exp_err == 2) begin
      check("R6 timeout error", {29'd0, err, err_code}, 32'h6);
      check("R6 no release", rst_ctrl, 32'h0);
      pll_lock = 1'b0;
      cont = 1'b1;
      @(negedge clk) cont = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 error holds", {29'd0, err, err_code, done}, 32'hC);
      return;
    end
    check("R5 no error", {30'd0, err, done}, 32'h0);
    @(negedge clk) check("R5 strobe single", {31'd0, pll_stat_we}, 32'h0);
    check("R7 step 1", rst_ctrl, 32'h40);
    @(negedge clk) check("R7 step 2", rst_ctrl, 32'hC0);
    @(negedge clk) check("R7 step 3", rst_ctrl, 32'hD0);
    pll_lock = 1'b0;
    repeat (4) @(negedge clk);
    if (poke != 0) begin
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      check("R1 start ignored in hold", pll_ctrl, 32'h0B00_0000);
    end
    check("R8 hold", {rst_ctrl[30:0], done}, {31'hD0, 1'b0});
    cont = 1'b1;
    @(negedge clk) cont = 1'b0;
    check("R8 phase two word", rst_ctrl, 32'h1FF0);
    check("R8 done not yet", {31'd0, done}, 32'h0);
    @(negedge clk) check("R8 done", {30'd0, done, err}, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset outputs", pll_div_cfg | pll_ctrl | rst_ctrl | pll_stat_wdata, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 idle flags", {28'd0, done, err, err_code}, 32'h0);
    for (int i = 0; i < NV; i++) run_seq(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);

    // Sync reset in the middle of the settle delay
    freq_code = 2'd2;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R9 reset mid-run", pll_div_cfg | pll_ctrl | rst_ctrl, 32'h0);
    // cont while idle must release nothing
    cont = 1'b1;
    @(negedge clk) cont = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 cont ignored idle", {rst_ctrl[29:0], done, err}, 32'h0);
    // Restart after the reset runs a full sequence
    run_seq(2, 5, 0, 0);
    finished = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule